// File: doc/BRIEF.md
# Compare Waveform Generator with Buffered Updates

This block sits beside a free-running or restartable counter. It compares the counter value against two compare channels and a period value, and from that it drives two waveform outputs. Four modes set the shape of the wave. The two frequency modes give a square wave that toggles on each compare hit. The two PWM modes give an output whose level depends on which side of the compare value the count lies. The block also decides the counter's top value, raises a restart request when the count reaches its end point, and can invert each output.

Compare and period values can be written straight into the active registers. They can also be staged in shadow buffers that take effect only when the counter wraps or when an explicit update command arrives. A lock input holds staged values back so that several registers can be changed together. The counter itself lives outside the block and only its value and direction come in.

Top module: `cmp_wavegen`

## Requirements
- R1: After reset the active compare registers hold 0, the active period holds the all-ones value, every pending flag, match flag, event and internal wave level is 0, and so each `wave` bit equals its `out_inv` bit.
- R2: `top` is combinational. With PERIOD_TOP = 0 it is the all-ones value in modes 0 (free-running frequency) and 2 (free-running PWM), and the active channel 0 compare value in modes 1 (frequency, channel 0 top) and 3 (PWM, channel 0 top). With PERIOD_TOP = 1 it is the active period value in every mode.
- R3: `clr_req` is combinational and is high when counting up with `count == top`, or counting down (`count_down` = 1) with `count == 0`.
- R4: In modes 0 and 1, a channel's internal level toggles on the clock edge where `count` equals that channel's active compare value, and otherwise holds.
- R5: In modes 2 and 3, a channel's internal level is loaded on each edge with `count < cmp` when counting up, or with `count <= cmp` when counting down.
- R6: `wave[i]` is the internal level of channel i XOR `out_inv[i]`, combinationally.
- R7: `match_flag[i]` is set on the edge after a compare hit on channel i and stays set until an edge with `flag_clr[i]` high and no hit; a hit wins over a clear.
- R8: `match_evt[i]` is a one-cycle pulse on the edge after a hit when `evt_en[i]` is high, and `ovf_evt` pulses on the edge after a cycle with `clr_req` high when `ovf_evt_en` is high.
- R9: A write with `wr_en` high targets `wr_sel` 0 = compare 0, 1 = compare 1, 2 = period, 3 = nothing. With `buf_mode` = 1 it stores into the buffer and sets `pend` bit 0, 1 or 2 respectively; with `buf_mode` = 0 it loads the active register on the next edge.
- R10: On an edge where (`clr_req` or `upd_cmd`) is high and `upd_lock` is low, every pending buffer is copied to its active register and its pending bit is cleared. A buffered write in that same cycle stays pending with its new value; a direct write in that cycle wins over the commit.
- R11: While `upd_lock` is high no buffer is committed, so pending bits and active values keep their state except for new writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| count | input | CNT_W | Current counter value |
| count_down | input | 1 | 1 when the counter counts down |
| mode | input | 2 | Waveform mode, 0..3 |
| out_inv | input | 2 | Per-channel output inversion |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 compare 0, 1 compare 1, 2 period |
| wr_data | input | CNT_W | Write data |
| buf_mode | input | 1 | 1 routes writes into the shadow buffers |
| upd_lock | input | 1 | Blocks buffer commits |
| upd_cmd | input | 1 | Explicit update command |
| flag_clr | input | 2 | Clears the match flags |
| evt_en | input | 2 | Enables match events per channel |
| ovf_evt_en | input | 1 | Enables the wrap event |
| wave | output | 2 | Waveform outputs |
| top | output | CNT_W | Top value for the counter |
| clr_req | output | 1 | Restart request to the counter |
| match_flag | output | 2 | Sticky match flags |
| match_evt | output | 2 | One-cycle match events |
| ovf_evt | output | 1 | One-cycle wrap event |
| pend | output | 3 | Buffer pending bits: compare 0, compare 1, period |

## Verification
The bench builds two copies with a 6-bit count so that every value, including the all-ones top, can be reached by sweeps. One copy uses PERIOD_TOP = 0 and the other PERIOD_TOP = 1, so both top-selection variants are exercised under the same stimulus. The narrow width makes compare hits, wraps in both directions, and commits that collide with writes frequent in the random phase.

// File: rtl/cwg_pkg.sv
package cwg_pkg;

  typedef enum logic [1:0] {
    MODE_FREQ_FREE = 2'd0,
    MODE_FREQ_CC0  = 2'd1,
    MODE_PWM_FREE  = 2'd2,
    MODE_PWM_CC0   = 2'd3
  } cwg_mode_e;

  typedef enum logic [1:0] {
    SLOT_CMP0   = 2'd0,
    SLOT_CMP1   = 2'd1,
    SLOT_PERIOD = 2'd2,
    SLOT_NONE   = 2'd3
  } cwg_slot_e;

  localparam int NUM_CH   = 2;
  localparam int NUM_SLOT = 3;

  function automatic logic mode_is_pwm(input logic [1:0] m);
    return m[1];
  endfunction

  function automatic logic mode_top_cc0(input logic [1:0] m);
    return m[0];
  endfunction

endpackage

// File: rtl/cwg_shadow.sv
module cwg_shadow #(
  parameter int W = 16,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         buf_mode,
  input  logic         wr_hit,
  input  logic [W-1:0] wr_data,
  input  logic         commit,
  output logic [W-1:0] act,
  output logic         pend
);

  logic [W-1:0] shadow_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act      <= RST_VAL;
      shadow_q <= '0;
      pend     <= 1'b0;
    end else begin
      if (commit && pend) begin
        act  <= shadow_q;
        pend <= 1'b0;
      end
      if (wr_hit) begin
        if (buf_mode) begin
          shadow_q <= wr_data;
          pend     <= 1'b1;
        end else begin
          act <= wr_data;
        end
      end
    end
  end

endmodule

// File: rtl/cwg_channel.sv
module cwg_channel #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] count,
  input  logic [W-1:0] cmp,
  input  logic         pwm,
  input  logic         down,
  input  logic         flag_clr,
  input  logic         evt_en,
  output logic         hit,
  output logic         level_q,
  output logic         flag,
  output logic         evt
);

  function automatic logic pwm_level(input logic [W-1:0] c,
                                     input logic [W-1:0] t,
                                     input logic d);
    return d ? (c <= t) : (c < t);
  endfunction

  assign hit = (count == cmp);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= 1'b0;
      flag    <= 1'b0;
      evt     <= 1'b0;
    end else begin
      if (pwm)      level_q <= pwm_level(count, cmp, down);
      else if (hit) level_q <= ~level_q;
      flag <= hit | (flag & ~flag_clr);
      evt  <= hit & evt_en;
    end
  end

endmodule

// File: rtl/cmp_wavegen.sv
module cmp_wavegen #(
  parameter int CNT_W      = 16,
  parameter bit PERIOD_TOP = (CNT_W == 8)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] count,
  input  logic             count_down,
  input  logic [1:0]       mode,
  input  logic [1:0]       out_inv,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             buf_mode,
  input  logic             upd_lock,
  input  logic             upd_cmd,
  input  logic [1:0]       flag_clr,
  input  logic [1:0]       evt_en,
  input  logic             ovf_evt_en,
  output logic [1:0]       wave,
  output logic [CNT_W-1:0] top,
  output logic             clr_req,
  output logic [1:0]       match_flag,
  output logic [1:0]       match_evt,
  output logic             ovf_evt,
  output logic [2:0]       pend
);
  import cwg_pkg::*;

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  function automatic logic [CNT_W-1:0] pick_top(input logic [1:0] m,
                                                input logic [CNT_W-1:0] c0,
                                                input logic [CNT_W-1:0] p);
    if (PERIOD_TOP)          return p;
    else if (mode_top_cc0(m)) return c0;
    else                      return CNT_MAX;
  endfunction

  logic [CNT_W-1:0] act_val [NUM_SLOT];
  logic [NUM_SLOT-1:0] wr_hit;
  logic             wrap;
  logic             commit_go;
  logic [NUM_CH-1:0] hit;
  logic [NUM_CH-1:0] wave_int;

  assign top       = pick_top(mode, act_val[SLOT_CMP0], act_val[SLOT_PERIOD]);
  assign wrap      = count_down ? (count == '0) : (count == top);
  assign clr_req   = wrap;
  assign commit_go = (wrap | upd_cmd) & ~upd_lock;

  for (genvar s = 0; s < NUM_SLOT; s++) begin : g_slot
    localparam logic [CNT_W-1:0] RV = (s == SLOT_PERIOD) ? CNT_MAX : '0;
    assign wr_hit[s] = wr_en && (wr_sel == s[1:0]);
    cwg_shadow #(.W(CNT_W), .RST_VAL(RV)) u_shadow (
      .clk      (clk),
      .rst_n    (rst_n),
      .buf_mode (buf_mode),
      .wr_hit   (wr_hit[s]),
      .wr_data  (wr_data),
      .commit   (commit_go),
      .act      (act_val[s]),
      .pend     (pend[s])
    );
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    cwg_channel #(.W(CNT_W)) u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .count    (count),
      .cmp      (act_val[i]),
      .pwm      (mode_is_pwm(mode)),
      .down     (count_down),
      .flag_clr (flag_clr[i]),
      .evt_en   (evt_en[i]),
      .hit      (hit[i]),
      .level_q  (wave_int[i]),
      .flag     (match_flag[i]),
      .evt      (match_evt[i])
    );
  end

  assign wave = wave_int ^ out_inv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovf_evt <= 1'b0;
    else        ovf_evt <= wrap & ovf_evt_en;
  end

endmodule

// File: rtl/cmp_wavegen_chk.sv
module cmp_wavegen_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       hit,
  input logic [1:0]       wave_int,
  input logic [1:0]       mode,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] cmp0,
  input logic             count_down,
  input logic             commit_go,
  input logic [2:0]       pend,
  input logic             wr_en,
  input logic [1:0]       wr_sel,
  input logic             upd_lock,
  input logic [1:0]       match_flag,
  input logic [1:0]       match_evt,
  input logic [1:0]       evt_en
);

  a_r7_flag_ch0: assert property (@(posedge clk) disable iff (!rst_n)
    hit[0] |=> match_flag[0]);

  a_r7_flag_ch1: assert property (@(posedge clk) disable iff (!rst_n)
    hit[1] |=> match_flag[1]);

  a_r8_evt_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    match_evt[0] |-> $past(hit[0] && evt_en[0]));

  a_r4_freq_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode[1] && hit[0]) |=> (wave_int[0] != $past(wave_int[0])));

  a_r5_pwm_up_high: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[1] && !count_down && (count < cmp0)) |=> wave_int[0]);

  a_r10_commit_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_go && pend[0] && !(wr_en && wr_sel == 2'd0)) |=> !pend[0]);

  a_r11_lock_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_lock && !wr_en) |=> $stable(pend));

endmodule

bind cmp_wavegen cmp_wavegen_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .hit        (hit),
  .wave_int   (wave_int),
  .mode       (mode),
  .count      (count),
  .cmp0       (act_val[0]),
  .count_down (count_down),
  .commit_go  (commit_go),
  .pend       (pend),
  .wr_en      (wr_en),
  .wr_sel     (wr_sel),
  .upd_lock   (upd_lock),
  .match_flag (match_flag),
  .match_evt  (match_evt),
  .evt_en     (evt_en)
);

// File: tb/test_cmp_wavegen.sv
module test_cmp_wavegen;

  localparam int W    = 6;
  localparam int MAXV = 63;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [W-1:0] cnt = '0;
  logic         down = 1'b0;
  logic [1:0]   md = 2'd0;
  logic [1:0]   inv = 2'd0;
  logic         wr_en = 1'b0;
  logic [1:0]   wr_sel = 2'd0;
  logic [W-1:0] wr_data = '0;
  logic         buf_mode = 1'b0;
  logic         lock = 1'b0;
  logic         upd = 1'b0;
  logic [1:0]   fclr = 2'd0;
  logic [1:0]   een = 2'd0;
  logic         oen = 1'b0;

  logic [1:0]   wave_o [2];
  logic [W-1:0] top_o  [2];
  logic         clr_o  [2];
  logic [1:0]   flag_o [2];
  logic [1:0]   mevt_o [2];
  logic         oevt_o [2];
  logic [2:0]   pend_o [2];

  cmp_wavegen #(.CNT_W(W), .PERIOD_TOP(1'b0)) i_cmp_wavegen (
    .clk(clk), .rst_n(rst_n), .count(cnt), .count_down(down), .mode(md),
    .out_inv(inv), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .buf_mode(buf_mode), .upd_lock(lock), .upd_cmd(upd), .flag_clr(fclr),
    .evt_en(een), .ovf_evt_en(oen), .wave(wave_o[0]), .top(top_o[0]),
    .clr_req(clr_o[0]), .match_flag(flag_o[0]), .match_evt(mevt_o[0]),
    .ovf_evt(oevt_o[0]), .pend(pend_o[0]));

  cmp_wavegen #(.CNT_W(W), .PERIOD_TOP(1'b1)) i_cmp_wavegen_per (
    .clk(clk), .rst_n(rst_n), .count(cnt), .count_down(down), .mode(md),
    .out_inv(inv), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .buf_mode(buf_mode), .upd_lock(lock), .upd_cmd(upd), .flag_clr(fclr),
    .evt_en(een), .ovf_evt_en(oen), .wave(wave_o[1]), .top(top_o[1]),
    .clr_req(clr_o[1]), .match_flag(flag_o[1]), .match_evt(mevt_o[1]),
    .ovf_evt(oevt_o[1]), .pend(pend_o[1]));

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // reference model state, indexed [instance][register]
  int mact [2][3];
  int mbuf [2][3];
  bit mvld [2][3];
  bit mwq  [2][2];
  bit mflg [2][2];
  bit mevt [2][2];
  bit movf [2];

  always @(negedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < 2; k++) begin
        for (int r = 0; r < 3; r++) begin
          mact[k][r] = (r == 2) ? MAXV : 0;
          mbuf[k][r] = 0;
          mvld[k][r] = 1'b0;
        end
        for (int i = 0; i < 2; i++) begin
          mwq[k][i] = 1'b0; mflg[k][i] = 1'b0; mevt[k][i] = 1'b0;
        end
        movf[k] = 1'b0;
      end
    end else begin
      for (int k = 0; k < 2; k++) begin
        int  ptop;
        bit  wrp, go;
        bit  h [2];
        ptop = (k == 1) ? mact[k][2] : (md[0] ? mact[k][0] : MAXV);
        wrp  = down ? (int'(cnt) == 0) : (int'(cnt) == ptop);
        chk("R2", "top", int'(top_o[k]), ptop);
        chk("R3", "clr_req", int'(clr_o[k]), int'(wrp));
        for (int i = 0; i < 2; i++) begin
          chk(md[1] ? "R5" : "R4", "wave", int'(wave_o[k][i]), int'(mwq[k][i] ^ inv[i]));
          chk("R7", "match_flag", int'(flag_o[k][i]), int'(mflg[k][i]));
          chk("R8", "match_evt", int'(mevt_o[k][i]), int'(mevt[k][i]));
        end
        chk("R8", "ovf_evt", int'(oevt_o[k]), int'(movf[k]));
        for (int r = 0; r < 3; r++)
          chk("R9", "pend", int'(pend_o[k][r]), int'(mvld[k][r]));
        // next state
        for (int i = 0; i < 2; i++) begin
          h[i] = (int'(cnt) == mact[k][i]);
          if (md[1]) mwq[k][i] = down ? (int'(cnt) <= mact[k][i]) : (int'(cnt) < mact[k][i]);
          else if (h[i]) mwq[k][i] = ~mwq[k][i];
          mflg[k][i] = h[i] | (mflg[k][i] & ~fclr[i]);
          mevt[k][i] = h[i] & een[i];
        end
        movf[k] = wrp & oen;
        go = (wrp | upd) & ~lock;
        for (int r = 0; r < 3; r++) begin
          if (go && mvld[k][r]) begin
            mact[k][r] = mbuf[k][r];
            mvld[k][r] = 1'b0;
          end
          if (wr_en && int'(wr_sel) == r) begin
            if (buf_mode) begin mbuf[k][r] = int'(wr_data); mvld[k][r] = 1'b1; end
            else mact[k][r] = int'(wr_data);
          end
        end
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [1:0] sel, input int val, input bit bm);
    wr_en = 1'b1; wr_sel = sel; wr_data = W'(val); buf_mode = bm;
    step(1);
    wr_en = 1'b0;
  endtask

  task automatic sweep(input bit dn);
    down = dn;
    for (int v = 0; v <= MAXV; v++) begin
      cnt = dn ? W'(MAXV - v) : W'(v);
      step(1);
    end
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset values seen at the ports
    chk("R1", "wave", int'(wave_o[0]), 0);
    chk("R1", "pend", int'(pend_o[0]), 0);
    chk("R1", "match_flag", int'(flag_o[0]), 0);
    chk("R1", "top", int'(top_o[0]), MAXV);
    chk("R1", "top period variant", int'(top_o[1]), MAXV);
    step(1);

    // direct writes
    wr(2'd0, 20, 1'b0);
    wr(2'd1, 8, 1'b0);
    wr(2'd2, 30, 1'b0);
    een = 2'b11; oen = 1'b1;

    for (int m = 0; m < 4; m++) begin
      md = 2'(m);
      inv = 2'(m);
      sweep(1'b0);
      fclr = 2'b11; step(1); fclr = 2'b00;
      sweep(1'b1);
    end

    // R6: inversion applied combinationally
    md = 2'd2; inv = 2'b00; down = 1'b0; cnt = 6'd10;
    step(2);
    inv = 2'b01;
    @(negedge clk);
    chk("R6", "wave[0] inverted", int'(wave_o[0][0]), 0);
    step(1);
    inv = 2'b00;
    @(negedge clk);
    chk("R6", "wave[0] plain", int'(wave_o[0][0]), 1);
    step(1);

    // buffered update of compare 0 under lock, then release
    md = 2'd1; cnt = 6'd5;
    wr(2'd0, 40, 1'b1);
    @(negedge clk);
    chk("R9", "pend[0] after buffered write", int'(pend_o[0][0]), 1);
    chk("R9", "top unchanged by buffered write", int'(top_o[0]), 20);
    step(1);
    lock = 1'b1; upd = 1'b1;
    step(1);
    upd = 1'b0;
    @(negedge clk);
    chk("R11", "pend[0] kept under lock", int'(pend_o[0][0]), 1);
    chk("R11", "top kept under lock", int'(top_o[0]), 20);
    step(1);
    lock = 1'b0; upd = 1'b1;
    step(1);
    upd = 1'b0;
    @(negedge clk);
    chk("R10", "top after commit", int'(top_o[0]), 40);
    chk("R10", "pend[0] after commit", int'(pend_o[0][0]), 0);
    step(1);

    // random phase
    for (int n = 0; n < 4000; n++) begin
      cnt      = W'($urandom);
      down     = ($urandom % 4) == 0;
      if ((n % 97) == 0) md = 2'($urandom);
      inv      = 2'($urandom);
      wr_en    = ($urandom % 5) == 0;
      wr_sel   = 2'($urandom);
      wr_data  = W'($urandom);
      buf_mode = ($urandom % 3) != 0;
      lock     = ($urandom % 4) == 0;
      upd      = ($urandom % 8) == 0;
      fclr     = 2'($urandom);
      een      = 2'($urandom);
      oen      = $urandom;
      step(1);
    end
    wr_en = 1'b0;
    step(2);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule